// File: doc/BRIEF.md
# Parallel NOR Flash Command Emulator

This block is a synthesizable stand-in for the control side of a byte-wide parallel NOR flash. The bus is asynchronous in style: address, write data, chip-enable, output-enable, write-enable and a bus reset, all active low where marked `_n`. A fast system clock samples these pins. A small register array takes the place of the memory cells. Reads behave like a plain ROM. Every change to the contents has to go through a fixed-length unlock command sequence, and only two kinds of change exist: byte programming, which can only clear bits, and whole-array erase, which sets every bit to one.

Each program or erase runs for a parameterized number of clock cycles. During that time the ready output is low. A read in that window returns only a polling byte, not the array contents. The low boot region can be write-protected by a dedicated command sequence. The protection is a one-way bit that only a power-on reset clears. While it is set, program commands to the region are dropped and erase leaves the region unchanged.

In all command sequences below, "U1" is the address parameter `UNLK_A` (default 0x55) and "U2" is `UNLK_B` (default 0xAA). The boot region is every address below 2^`BOOT_W` (0x00 to 0x0F by default).

Top module: `nce_flash_emu`

## Requirements
- R1: `bus_dout_en` is high, and `bus_dout` carries data, only while `bus_ce_n` and `bus_oe_n` are low and `bus_we_n` is high (three clocks of latency). Otherwise `bus_dout_en` is low and `bus_dout` is 0x00.
- R2: The write sequence 0xAA@U1, 0x55@U2, 0xA0@U1, then D@T programs address T. The stored byte becomes the old byte AND D.
- R3: The six writes 0xAA@U1, 0x55@U2, 0x80@U1, 0xAA@U1, 0x55@U2, 0x10@U1 erase the array to 0xFF. When lock is set, the boot region is excluded.
- R4: The same six writes, except that the last one is 0x40@U1, set the lock bit. Only `por_n` clears this bit; bus reset and erase do not.
- R5: While lock is set, a program command aimed at the boot region is dropped. It starts no busy period and changes no byte, and erase keeps the boot bytes.
- R6: A write whose address or data does not match the expected step returns the decoder to idle. A new sequence must then start from its first step.
- R7: Low `bus_rst_n` returns the decoder to idle, aborts a running operation without changing the array, and raises `rdy`.
- R8: `rdy` falls after the last write of a program or erase and stays low for `PROG_CYC` or `ERASE_CYC` clocks respectively.
- R9: A read while busy returns {~D[7], 7'b0} during a program of D, and 0x00 during an erase.
- R10: Bus writes made while busy are ignored and do not advance any command sequence.
- R11: The write address is taken when CE_n and WE_n first both become low. The write data is taken when either of them rises.
- R12: After `por_n`, every byte reads 0xFF, lock is clear and `rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| por_n | input | 1 | Power-on reset, async, active low |
| bus_rst_n | input | 1 | Bus reset, active low |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data or polling byte |
| bus_dout_en | output | 1 | Read data driven (low means high impedance) |
| rdy | output | 1 | High when no program or erase is running |

## Verification
The bench builds the block with a 256-byte array, a 16-byte boot region, `PROG_CYC`=40 and `ERASE_CYC`=120. These short busy times let one run cover programs, several erases and lock handling. The busy windows are still long enough for a full read to land inside them, so the polling byte can be observed. They also leave room for a bus reset in the middle of an operation and for a complete command sequence that has to be ignored while busy.

// File: rtl/nce_pkg.sv
package nce_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_U1, ST_U2, ST_PROG, ST_E3, ST_E4, ST_E5
    } seq_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_PROG, OP_ERASE
    } op_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_EXT    = 8'h80;
    localparam logic [7:0] CMD_ERASE  = 8'h10;
    localparam logic [7:0] CMD_LOCK   = 8'h40;
endpackage

// File: rtl/nce_bus_sync.sv
module nce_bus_sync #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic              rst_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_act_o,
    output logic              bus_rst_o,
    output logic              wr_pulse_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);
    localparam int CTL_W = 4; // {ce_n, oe_n, we_n, rst_n}

    typedef struct packed {
        logic [ADDR_W-1:0] a1;
        logic [ADDR_W-1:0] a2;
        logic [7:0]        d1;
        logic [7:0]        d2;
        logic [CTL_W-1:0]  c1;
        logic [CTL_W-1:0]  c2;
        logic              wr_prev;
        logic [ADDR_W-1:0] cap_a;
        logic              pulse;
        logic [ADDR_W-1:0] p_a;
        logic [7:0]        p_d;
    } sync_t;

    sync_t s_d, s_q;
    logic  wr_act;

    always_comb begin
        s_d    = s_q;
        s_d.a1 = addr_i;
        s_d.a2 = s_q.a1;
        s_d.d1 = din_i;
        s_d.d2 = s_q.d1;
        s_d.c1 = {ce_n_i, oe_n_i, we_n_i, rst_n_i};
        s_d.c2 = s_q.c1;

        // write window: chip enable and write enable both low
        wr_act      = ~s_q.c2[3] & ~s_q.c2[1];
        s_d.wr_prev = wr_act;
        s_d.pulse   = 1'b0;
        if (wr_act && !s_q.wr_prev) begin
            s_d.cap_a = s_q.a2;
        end
        if (!wr_act && s_q.wr_prev) begin
            s_d.pulse = 1'b1;
            s_d.p_a   = s_q.cap_a;
            s_d.p_d   = s_q.d2;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q         <= '0;
            s_q.c1      <= '1;
            s_q.c2      <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o     = s_q.a2;
    assign rd_act_o   = ~s_q.c2[3] & ~s_q.c2[2] & s_q.c2[1];
    assign bus_rst_o  = ~s_q.c2[0];
    assign wr_pulse_o = s_q.pulse;
    assign wr_addr_o  = s_q.p_a;
    assign wr_data_o  = s_q.p_d;
endmodule

// File: rtl/nce_cmd_seq.sv
module nce_cmd_seq
    import nce_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                BOOT_W = 4,
    parameter logic [ADDR_W-1:0] UNLK_A = 'h55,
    parameter logic [ADDR_W-1:0] UNLK_B = 'hAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_rst,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              locked,
    output op_e               start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [7:0]        start_data,
    output logic              set_lock
);
    typedef struct packed {
        seq_e st;
    } seq_t;

    seq_t q_d, q_q;
    logic in_boot;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] dv,
                                 input logic [ADDR_W-1:0] ea, input logic [7:0] ed);
        return (a == ea) && (dv == ed);
    endfunction

    assign in_boot = ~|wr_addr[ADDR_W-1:BOOT_W];

    always_comb begin
        q_d        = q_q;
        start_op   = OP_NONE;
        start_addr = wr_addr;
        start_data = wr_data;
        set_lock   = 1'b0;
        if (bus_rst) begin
            q_d.st = ST_IDLE;
        end else if (wr_pulse && !busy) begin
            q_d.st = ST_IDLE;
            case (q_q.st)
                ST_IDLE: if (hit(wr_addr, wr_data, UNLK_A, KEY_FIRST))  q_d.st = ST_U1;
                ST_U1:   if (hit(wr_addr, wr_data, UNLK_B, KEY_SECOND)) q_d.st = ST_U2;
                ST_U2: begin
                    if (hit(wr_addr, wr_data, UNLK_A, CMD_PROG))     q_d.st = ST_PROG;
                    else if (hit(wr_addr, wr_data, UNLK_A, CMD_EXT)) q_d.st = ST_E3;
                end
                ST_E3:   if (hit(wr_addr, wr_data, UNLK_A, KEY_FIRST))  q_d.st = ST_E4;
                ST_E4:   if (hit(wr_addr, wr_data, UNLK_B, KEY_SECOND)) q_d.st = ST_E5;
                ST_E5: begin
                    if (hit(wr_addr, wr_data, UNLK_A, CMD_ERASE))     start_op = OP_ERASE;
                    else if (hit(wr_addr, wr_data, UNLK_A, CMD_LOCK)) set_lock = 1'b1;
                end
                ST_PROG: if (!(locked && in_boot)) start_op = OP_PROG;
                default: q_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q_q <= '{st: ST_IDLE};
        else        q_q <= q_d;
    end
endmodule

// File: rtl/nce_op_timer.sv
module nce_op_timer
    import nce_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PROG_CYC  = 300,
    parameter int ERASE_CYC = 2000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_rst,
    input  op_e               start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    output logic              busy,
    output logic              poll_bit,
    output op_e               commit_op,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [7:0]        commit_data
);
    localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d       = t_q;
        commit_op = OP_NONE;
        if (bus_rst) begin
            t_d.busy = 1'b0;
            t_d.cnt  = '0;
        end else if (t_q.busy) begin
            if (t_q.cnt == CNT_W'(1)) begin
                t_d.busy  = 1'b0;
                t_d.cnt   = '0;
                commit_op = t_q.op;
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end else if (start_op != OP_NONE) begin
            t_d.busy = 1'b1;
            t_d.op   = start_op;
            t_d.addr = start_addr;
            t_d.data = start_data;
            t_d.cnt  = (start_op == OP_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) t_q <= '{busy: 1'b0, cnt: '0, op: OP_NONE, addr: '0, data: '0};
        else        t_q <= t_d;
    end

    assign busy        = t_q.busy;
    assign poll_bit    = (t_q.op == OP_PROG) ? ~t_q.data[7] : 1'b0;
    assign commit_addr = t_q.addr;
    assign commit_data = t_q.data;
endmodule

// File: rtl/nce_array.sv
module nce_array
    import nce_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BOOT_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  op_e               commit_op,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [7:0]        commit_data,
    input  logic              set_lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              locked
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BOOT_DEPTH = 1 << BOOT_W;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic                  lock;
    } arr_t;

    arr_t m_d, m_q;
    logic [DEPTH-1:0] in_boot;

    for (genvar g = 0; g < DEPTH; g++) begin : g_boot_map
        if (g < BOOT_DEPTH) begin : g_b
            assign in_boot[g] = 1'b1;
        end else begin : g_m
            assign in_boot[g] = 1'b0;
        end
    end

    always_comb begin
        m_d = m_q;
        if (set_lock) m_d.lock = 1'b1;
        case (commit_op)
            OP_PROG:  m_d.mem[commit_addr] = m_q.mem[commit_addr] & commit_data;
            OP_ERASE: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!(m_q.lock && in_boot[i])) m_d.mem[i] = 8'hFF;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_q.mem  <= '1;
            m_q.lock <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign rd_data = m_q.mem[rd_addr];
    assign locked  = m_q.lock;
endmodule

// File: rtl/nce_flash_emu.sv
module nce_flash_emu
    import nce_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                BOOT_W    = 4,
    parameter int                PROG_CYC  = 300,
    parameter int                ERASE_CYC = 2000,
    parameter logic [ADDR_W-1:0] UNLK_A    = 'h55,
    parameter logic [ADDR_W-1:0] UNLK_B    = 'hAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic              bus_dout_en,
    output logic              rdy
);
    typedef struct packed {
        logic       en;
        logic [7:0] data;
    } out_t;

    logic [ADDR_W-1:0] rd_addr;
    logic              rd_act, bus_rst, wr_pulse;
    logic [ADDR_W-1:0] wr_addr, start_addr, commit_addr;
    logic [7:0]        wr_data, start_data, commit_data, rd_data;
    logic              busy, poll_bit, locked, set_lock;
    op_e               start_op, commit_op;
    out_t              o_d, o_q;

    nce_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .por_n(por_n),
        .addr_i(bus_addr), .din_i(bus_din),
        .ce_n_i(bus_ce_n), .oe_n_i(bus_oe_n), .we_n_i(bus_we_n), .rst_n_i(bus_rst_n),
        .addr_o(rd_addr), .rd_act_o(rd_act), .bus_rst_o(bus_rst),
        .wr_pulse_o(wr_pulse), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    nce_cmd_seq #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) u_seq (
        .clk(clk), .por_n(por_n), .bus_rst(bus_rst),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .locked(locked),
        .start_op(start_op), .start_addr(start_addr), .start_data(start_data),
        .set_lock(set_lock)
    );

    nce_op_timer #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .por_n(por_n), .bus_rst(bus_rst),
        .start_op(start_op), .start_addr(start_addr), .start_data(start_data),
        .busy(busy), .poll_bit(poll_bit),
        .commit_op(commit_op), .commit_addr(commit_addr), .commit_data(commit_data)
    );

    nce_array #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_arr (
        .clk(clk), .por_n(por_n),
        .commit_op(commit_op), .commit_addr(commit_addr), .commit_data(commit_data),
        .set_lock(set_lock), .rd_addr(rd_addr),
        .rd_data(rd_data), .locked(locked)
    );

    always_comb begin
        o_d.en   = rd_act;
        o_d.data = 8'h00;
        if (rd_act) o_d.data = busy ? {poll_bit, 7'b0} : rd_data;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign bus_dout    = o_q.data;
    assign bus_dout_en = o_q.en;
    assign rdy         = ~busy;
endmodule

// File: rtl/nce_flash_emu_chk.sv
module nce_flash_emu_chk #(
    parameter int ADDR_W = 8,
    parameter int BOOT_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              bus_ce_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic [7:0]        bus_dout,
    input logic              bus_dout_en,
    input logic              rdy,
    input logic              wr_pulse,
    input logic              bus_rst,
    input logic              locked,
    input logic [1:0]        commit_op,
    input logic [ADDR_W-1:0] commit_addr
);
    localparam logic [1:0] PROG_CODE = 2'd1;

    AST_READ_GATE: assert property (@(posedge clk) disable iff (!por_n)
        bus_dout_en |-> (!$past(bus_ce_n, 3) && !$past(bus_oe_n, 3) && $past(bus_we_n, 3))); // R1
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        !bus_dout_en |-> (bus_dout == 8'h00)); // R1
    AST_POLL_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        (bus_dout_en && $past(!rdy)) |-> (bus_dout[6:0] == 7'b0)); // R9
    AST_RDY_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rdy) |-> $past(wr_pulse)); // R8
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        $past(locked) |-> locked); // R4
    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!por_n)
        (locked && commit_op == PROG_CODE) |-> (|commit_addr[ADDR_W-1:BOOT_W])); // R5
    AST_RST_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        bus_rst |=> rdy); // R7
endmodule

bind nce_flash_emu nce_flash_emu_chk #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_chk (
    .clk(clk), .por_n(por_n),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .rdy(rdy),
    .wr_pulse(wr_pulse), .bus_rst(bus_rst), .locked(locked),
    .commit_op(commit_op), .commit_addr(commit_addr)
);

// File: tb/nce_flash_emu_tb_top.sv
module nce_flash_emu_tb_top;
    localparam int PROG_CYC  = 40;
    localparam int ERASE_CYC = 120;
    localparam int NV        = 28;

    // {kind[1:0], addr[7:0], data[7:0]}; kind 0 write, 1 read-compare, 2 wait ready
    localparam logic [17:0] VEC [0:NV-1] = '{
        {2'd0, 8'h55, 8'hAA}, {2'd0, 8'hAA, 8'h55}, {2'd0, 8'h55, 8'h80},
        {2'd0, 8'h55, 8'hAA}, {2'd0, 8'hAA, 8'h55}, {2'd0, 8'h55, 8'h10},
        {2'd2, 8'h00, 8'h00},
        {2'd1, 8'h20, 8'hFF}, {2'd1, 8'h03, 8'hFF}, {2'd1, 8'h9F, 8'hFF},
        {2'd0, 8'h55, 8'hAA}, {2'd0, 8'hAA, 8'h55}, {2'd0, 8'h55, 8'hA0},
        {2'd0, 8'h20, 8'h5A}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'h20, 8'h5A},
        {2'd0, 8'h55, 8'hAA}, {2'd0, 8'hAA, 8'h55}, {2'd0, 8'h55, 8'hA0},
        {2'd0, 8'h20, 8'hF0}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'h20, 8'h50},
        {2'd0, 8'h55, 8'hAA}, {2'd0, 8'hAA, 8'h55}, {2'd0, 8'h55, 8'hA0},
        {2'd0, 8'h03, 8'h0F}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'h03, 8'h0F}
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       bus_rst_n = 1'b1;
    logic       bus_ce_n = 1'b1;
    logic       bus_oe_n = 1'b1;
    logic       bus_we_n = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_dout_en;
    logic       rdy;

    int         n_tests = 0;
    int         n_fail  = 0;
    logic [7:0] rd_d;
    logic       rd_en;
    int         wcyc;

    always #4 clk = ~clk;

    nce_flash_emu #(.ADDR_W(8), .BOOT_W(4), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
        .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit glitch);
        @(negedge clk);
        bus_addr = a;
        bus_din  = glitch ? ~d : d;
        bus_ce_n = 1'b0;
        idle(2);
        bus_we_n = 1'b0;
        idle(3);
        if (glitch) bus_addr = ~a;
        bus_din = d;
        idle(3);
        bus_we_n = 1'b1;
        idle(3);
        bus_ce_n = 1'b1;
        idle(3);
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_ce_n = 1'b0;
        bus_oe_n = 1'b0;
        idle(6);
        rd_d  = bus_dout;
        rd_en = bus_dout_en;
        bus_oe_n = 1'b1;
        bus_ce_n = 1'b1;
        idle(4);
    endtask

    task automatic wait_rdy(output int cyc);
        cyc = 0;
        while (!rdy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic unlock();
        wr(8'h55, 8'hAA, 1'b0);
        wr(8'hAA, 8'h55, 1'b0);
    endtask

    task automatic prog(input logic [7:0] a, input logic [7:0] d);
        unlock();
        wr(8'h55, 8'hA0, 1'b0);
        wr(a, d, 1'b0);
    endtask

    task automatic ext_cmd(input logic [7:0] last);
        unlock();
        wr(8'h55, 8'h80, 1'b0);
        unlock();
        wr(8'h55, last, 1'b0);
    endtask

    task automatic bus_reset();
        @(negedge clk);
        bus_rst_n = 1'b0;
        idle(4);
        bus_rst_n = 1'b1;
        idle(4);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd(a);
        chk(rd_en && rd_d == exp, tag, rd_d, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        idle(3);
        por_n = 1'b1;
        idle(3);

        // R12: power-on state
        chk(rdy == 1'b1, "R12 rdy after por", {7'b0, rdy}, 8'h01);
        chk(bus_dout_en == 1'b0, "R12 dout_en idle", {7'b0, bus_dout_en}, 8'h00);
        rd_chk(8'h40, 8'hFF, "R12 erased after por");

        // R1: output gating
        @(negedge clk);
        bus_ce_n = 1'b1; bus_oe_n = 1'b0; bus_addr = 8'h40;
        idle(6);
        chk(bus_dout_en == 1'b0 && bus_dout == 8'h00, "R1 ce high no drive", bus_dout, 8'h00);
        bus_din = 8'h00; bus_ce_n = 1'b0; bus_we_n = 1'b0;
        idle(6);
        chk(bus_dout_en == 1'b0, "R1 we low no drive", {7'b0, bus_dout_en}, 8'h00);
        bus_we_n = 1'b1; bus_oe_n = 1'b1; bus_ce_n = 1'b1;
        idle(6);

        // R2 / R3 vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][17:16])
                2'd0: wr(VEC[i][15:8], VEC[i][7:0], 1'b0);
                2'd1: begin
                    rd(VEC[i][15:8]);
                    chk(rd_en && rd_d == VEC[i][7:0], (i < 10) ? "R3 table" : "R2 table",
                        rd_d, VEC[i][7:0]);
                end
                default: begin
                    wait_rdy(wcyc);
                    chk(rdy == 1'b1, "R8 table ready", {7'b0, rdy}, 8'h01);
                end
            endcase
        end

        // R11 and R9: captured address/data, polling during program
        unlock();
        wr(8'h55, 8'hA0, 1'b0);
        wr(8'h30, 8'h7E, 1'b1);
        rd(8'h30);
        chk(rd_en && rd_d == 8'h80, "R9 program poll", rd_d, 8'h80);
        chk(rdy == 1'b0, "R8 busy during program", {7'b0, rdy}, 8'h00);
        wait_rdy(wcyc);
        rd_chk(8'h30, 8'h7E, "R11 capture points");

        // R8: busy length
        prog(8'h31, 8'h0F);
        wait_rdy(wcyc);
        chk(wcyc <= PROG_CYC && wcyc >= PROG_CYC - 5, "R8 program duration", 8'(wcyc), 8'(PROG_CYC - 2));
        rd_chk(8'h31, 8'h0F, "R2 second program");

        // R6: wrong step
        wr(8'h55, 8'hAA, 1'b0);
        wr(8'hAA, 8'h33, 1'b0);
        wr(8'h55, 8'hA0, 1'b0);
        wr(8'h32, 8'h00, 1'b0);
        chk(rdy == 1'b1, "R6 no busy after bad step", {7'b0, rdy}, 8'h01);
        rd_chk(8'h32, 8'hFF, "R6 bad sequence ignored");

        // R7: reset mid-sequence
        unlock();
        bus_reset();
        wr(8'h55, 8'hA0, 1'b0);
        wr(8'h32, 8'h00, 1'b0);
        chk(rdy == 1'b1, "R7 sequence cleared", {7'b0, rdy}, 8'h01);
        rd_chk(8'h32, 8'hFF, "R7 sequence cleared data");

        // R7: reset aborts program
        prog(8'h33, 8'h00);
        bus_reset();
        chk(rdy == 1'b1, "R7 abort ready", {7'b0, rdy}, 8'h01);
        rd_chk(8'h33, 8'hFF, "R7 abort leaves byte");

        // R10 / R9 / R3: erase with unlocked boot, writes while busy
        prog(8'h06, 8'h3C);
        wait_rdy(wcyc);
        prog(8'h40, 8'h11);
        wait_rdy(wcyc);
        ext_cmd(8'h10);
        rd(8'h40);
        chk(rd_en && rd_d == 8'h00, "R9 erase poll", rd_d, 8'h00);
        prog(8'h35, 8'h00);
        wait_rdy(wcyc);
        idle(PROG_CYC + 10);
        rd_chk(8'h35, 8'hFF, "R10 write during busy ignored");
        rd_chk(8'h40, 8'hFF, "R3 erase main");
        rd_chk(8'h06, 8'hFF, "R3 erase boot when unlocked");

        // R4 / R5: lockout
        prog(8'h06, 8'h3C);
        wait_rdy(wcyc);
        ext_cmd(8'h40);
        prog(8'h05, 8'h00);
        chk(rdy == 1'b1, "R5 locked program no busy", {7'b0, rdy}, 8'h01);
        rd_chk(8'h05, 8'hFF, "R5 locked program ignored");
        prog(8'h42, 8'h00);
        wait_rdy(wcyc);
        rd_chk(8'h42, 8'h00, "R4 main still programmable");
        ext_cmd(8'h10);
        wait_rdy(wcyc);
        rd_chk(8'h06, 8'h3C, "R5 boot kept by erase");
        rd_chk(8'h42, 8'hFF, "R3 locked erase main");
        prog(8'h05, 8'h00);
        rd_chk(8'h05, 8'hFF, "R4 lock survives erase");
        bus_reset();
        prog(8'h05, 8'h00);
        rd_chk(8'h05, 8'hFF, "R4 lock survives bus reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule